// File: doc/BRIEF.md
# Inter-core Data Marshal Buffer

This block sits beside one core's private cache and remembers which cache blocks the current code segment has produced for the segment that follows it. Stores that commit with a generator tag have their block-aligned physical address captured in a small table of at most sixteen entries. Untagged stores, repeated addresses and arrivals into a full table never create entries. A full table sets a sticky overflow flag. Capture may be conservative, and pushing a block the consumer never reads is allowed.

A marshal command names the core that will run the next segment. The block then walks the table from the oldest entry to the newest. For each entry it reads the block from the local cache through a valid/ready read port. It then sends the block to the destination as a push request, with its own valid/ready handshake. Once every entry has been sent, the table and the overflow flag clear and a one-cycle completion pulse is raised. While a drain is running, new generator stores are held off by a busy output, and further marshal commands are not taken.

Top module: `marshal_buf`

## Requirements
- R1: After reset, busy, done, overflow, read-request valid and push valid are all low, and the table is empty.
- R2: Only a store with both `st_valid` and `st_gen` high is recorded. A store with `st_gen` low leaves no trace in a later drain.
- R3: The recorded and pushed block address is `st_addr[53:6]`, so the six offset bits of a 64-byte block are dropped.
- R4: A generator store to a block already in the table adds no second entry, whatever its offset.
- R5: The table holds 16 entries. A generator store of a new block into a full table is dropped and sets `overflow`, which stays high until the next drain completes. Sixteen distinct blocks do not set it.
- R6: A drain sends the entries in the order they were first recorded. For each entry, `rd_valid` with `rd_addr` waits for `rd_ready`, and the `rd_data` accepted on that handshake is then offered on `push_data`, with `push_addr` and the commanded `push_dest`, until `push_ready`.
- R7: From the cycle after an accepted marshal command until the cycle after `done`, `st_busy` is high, and generator stores presented during that time are not recorded. While `st_busy` is low, no read or push request is raised.
- R8: `done` is high for exactly one cycle at the end of each drain. Afterwards the table is empty and `overflow` is low.
- R9: A marshal command while the table is empty raises `done` without any read or push request.
- R10: A generator store and a marshal command accepted in the same idle cycle: the store is recorded and included in that drain.
- R11: A marshal command presented while a drain runs is ignored, and the running drain keeps its original destination.
- R12: Once raised, `rd_valid` and `push_valid` stay high, with address and data unchanged, until their ready input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store commits this cycle |
| st_gen | input | 1 | The committing store carries the generator tag |
| st_addr | input | 54 | Physical byte address of the store |
| st_busy | output | 1 | Drain in progress; generator stores must be held |
| mcmd_valid | input | 1 | Marshal command |
| mcmd_dest | input | 5 | Destination core of the marshal command |
| rd_valid | output | 1 | Local cache read request |
| rd_addr | output | 48 | Block address to read |
| rd_ready | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 512 | Block contents from the local cache |
| push_valid | output | 1 | Push request toward the remote cache |
| push_dest | output | 5 | Destination core |
| push_addr | output | 48 | Block address being pushed |
| push_data | output | 512 | Block contents being pushed |
| push_ready | input | 1 | Push accepted |
| done | output | 1 | One-cycle pulse at the end of a drain |
| overflow | output | 1 | Sticky flag: a generator block was dropped |

## Verification
The case that needs the most care is a generator store that lands in the same idle cycle as the marshal command. Without care, the drain could sample the fill count before the new entry counts. The bench drives both inputs on one falling edge. It then requires that the drain pushes exactly that block to the commanded core. The opposite case is a store and a second command arriving while a drain runs. Both must be dropped. This is judged by the push count and destination of the running drain, and by an immediately following drain that sends nothing.

// File: rtl/mb_pkg.sv
package mb_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_PUSH,
        SEQ_FIN
    } seq_state_e;
endpackage

// File: rtl/mb_addr_table.sv
module mb_addr_table #(
    parameter int ENTRIES = 16,
    parameter int BA_W    = 48,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [BA_W-1:0]  ins_blk,
    input  logic             clr,
    input  logic [CNT_W-1:0] sel_idx,
    output logic [CNT_W-1:0] fill,
    output logic [BA_W-1:0]  sel_blk,
    output logic             ovf
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0][BA_W-1:0] blk;
        logic [CNT_W-1:0]             fill;
        logic                         ovf;
    } tab_t;

    tab_t t_d, t_q;
    logic [ENTRIES-1:0] hit;

    // Entries are packed from slot 0 upward, so slot i is live when i < fill.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = (CNT_W'(i) < t_q.fill) && (t_q.blk[i] == ins_blk);
    end

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d.fill = '0;
            t_d.ovf  = 1'b0;
        end else if (ins_valid && !(|hit)) begin
            if (t_q.fill == CNT_W'(ENTRIES)) begin
                t_d.ovf = 1'b1;
            end else begin
                t_d.blk[t_q.fill[IDX_W-1:0]] = ins_blk;
                t_d.fill = t_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign fill    = t_q.fill;
    assign ovf     = t_q.ovf;
    assign sel_blk = t_q.blk[sel_idx[IDX_W-1:0]];
endmodule

// File: rtl/mb_drain_seq.sv
module mb_drain_seq
    import mb_pkg::*;
#(
    parameter int CID_W  = 5,
    parameter int DATA_W = 512,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CID_W-1:0]  cmd_dest,
    input  logic [CNT_W-1:0]  fill,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              push_ready,
    output logic [CNT_W-1:0]  idx,
    output logic              rd_valid,
    output logic              push_valid,
    output logic [CID_W-1:0]  push_dest,
    output logic [DATA_W-1:0] push_data,
    output logic              busy,
    output logic              done,
    output logic              clr
);
    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  idx;
        logic [CID_W-1:0]  dest;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    s_d.state = SEQ_READ;
                    s_d.idx   = '0;
                    s_d.dest  = cmd_dest;
                end
            end
            SEQ_READ: begin
                if (s_q.idx == fill) begin
                    s_d.state = SEQ_FIN;
                end else if (rd_ready) begin
                    s_d.data  = rd_data;
                    s_d.state = SEQ_PUSH;
                end
            end
            SEQ_PUSH: begin
                if (push_ready) begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.state = SEQ_READ;
                end
            end
            SEQ_FIN:  s_d.state = SEQ_IDLE;
            default:  s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign idx        = s_q.idx;
    assign rd_valid   = (s_q.state == SEQ_READ) && (s_q.idx != fill);
    assign push_valid = (s_q.state == SEQ_PUSH);
    assign push_dest  = s_q.dest;
    assign push_data  = s_q.data;
    assign busy       = (s_q.state != SEQ_IDLE);
    assign done       = (s_q.state == SEQ_FIN);
    assign clr        = (s_q.state == SEQ_FIN);
endmodule

// File: rtl/marshal_buf.sv
module marshal_buf #(
    parameter int PA_W    = 54,
    parameter int BLK_OFF = 6,
    parameter int ENTRIES = 16,
    parameter int CID_W   = 5,
    parameter int DATA_W  = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic                    st_gen,
    input  logic [PA_W-1:0]         st_addr,
    output logic                    st_busy,
    input  logic                    mcmd_valid,
    input  logic [CID_W-1:0]        mcmd_dest,
    output logic                    rd_valid,
    output logic [PA_W-BLK_OFF-1:0] rd_addr,
    input  logic                    rd_ready,
    input  logic [DATA_W-1:0]       rd_data,
    output logic                    push_valid,
    output logic [CID_W-1:0]        push_dest,
    output logic [PA_W-BLK_OFF-1:0] push_addr,
    output logic [DATA_W-1:0]       push_data,
    input  logic                    push_ready,
    output logic                    done,
    output logic                    overflow
);
    localparam int BA_W  = PA_W - BLK_OFF;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic             ins_valid;
    logic             clr;
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] idx;
    logic [BA_W-1:0]  sel_blk;

    assign ins_valid = st_valid && st_gen && !st_busy;

    mb_addr_table #(
        .ENTRIES (ENTRIES),
        .BA_W    (BA_W),
        .CNT_W   (CNT_W)
    ) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_blk   (st_addr[PA_W-1:BLK_OFF]),
        .clr       (clr),
        .sel_idx   (idx),
        .fill      (fill),
        .sel_blk   (sel_blk),
        .ovf       (overflow)
    );

    mb_drain_seq #(
        .CID_W  (CID_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (mcmd_valid),
        .cmd_dest   (mcmd_dest),
        .fill       (fill),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .push_ready (push_ready),
        .idx        (idx),
        .rd_valid   (rd_valid),
        .push_valid (push_valid),
        .push_dest  (push_dest),
        .push_data  (push_data),
        .busy       (st_busy),
        .done       (done),
        .clr        (clr)
    );

    assign rd_addr   = sel_blk;
    assign push_addr = sel_blk;
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
    parameter int BA_W   = 48,
    parameter int DATA_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_busy,
    input logic              done,
    input logic              overflow,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [BA_W-1:0]   rd_addr,
    input logic              push_valid,
    input logic              push_ready,
    input logic [BA_W-1:0]   push_addr,
    input logic [DATA_W-1:0] push_data
);
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    assert_push_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_data));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !overflow);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !done |=> overflow);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_busy |-> !rd_valid && !push_valid);
endmodule

bind marshal_buf mb_checker #(
    .BA_W   (PA_W - BLK_OFF),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_busy    (st_busy),
    .done       (done),
    .overflow   (overflow),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_addr  (push_addr),
    .push_data  (push_data)
);

// File: tb/marshal_buf_tb.sv
module marshal_buf_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid, st_gen;
    logic [53:0]  st_addr;
    logic         st_busy;
    logic         mcmd_valid;
    logic [4:0]   mcmd_dest;
    logic         rd_valid, rd_ready;
    logic [47:0]  rd_addr;
    logic [511:0] rd_data;
    logic         push_valid, push_ready;
    logic [4:0]   push_dest;
    logic [47:0]  push_addr;
    logic [511:0] push_data;
    logic         done, overflow;

    int vectors = 0;
    int miscompares = 0;
    int got_n = 0;
    int rd_n = 0;
    logic [4:0]  exp_dest = '0;
    logic [47:0] got_blk [32];
    bit          mon_on = 1'b0;

    always #2 clk = ~clk;

    marshal_buf u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_gen(st_gen), .st_addr(st_addr),
        .st_busy(st_busy), .mcmd_valid(mcmd_valid), .mcmd_dest(mcmd_dest),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .push_valid(push_valid), .push_dest(push_dest), .push_addr(push_addr),
        .push_data(push_data), .push_ready(push_ready), .done(done), .overflow(overflow)
    );

    function automatic logic [511:0] blk_data(input logic [47:0] a);
        return {8{a[47:32] ^ 16'h5AC3, a}};
    endfunction

    function automatic logic [47:0] mk_blk(input int k);
        return 48'h1234_0000_0000 + 48'(k * 37 + 5);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cache and remote side: ready patterns with stalls, changed just after each edge.
    initial begin
        int stall;
        stall = 0;
        rd_ready = 1'b0; push_ready = 1'b0; rd_data = '0;
        forever begin
            @(posedge clk); #1;
            stall++;
            rd_ready   = (stall % 3) != 1;
            push_ready = (stall % 4) != 2;
            rd_data    = blk_data(rd_addr);
        end
    end

    // Monitor at the falling edge: handshakes that complete at the next rising edge.
    initial begin
        bit       pv_wait;
        logic [47:0] pa_prev;
        pv_wait = 1'b0; pa_prev = '0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (pv_wait) begin
                    check("R12 push held", {63'd0, push_valid}, 64'd1);
                    check("R12 push addr stable", {16'd0, push_addr}, {16'd0, pa_prev});
                end
                pv_wait = push_valid && !push_ready;
                pa_prev = push_addr;
                if (rd_valid && rd_ready) rd_n++;
                if (push_valid && push_ready) begin
                    check("R6 push dest", {59'd0, push_dest}, {59'd0, exp_dest});
                    check("R6 push data", push_data[63:0], blk_data(push_addr)[63:0]);
                    check("R6 push data top", push_data[511:448], blk_data(push_addr)[511:448]);
                    if (got_n < 32) got_blk[got_n] = push_addr;
                    got_n++;
                end
            end
        end
    end

    task automatic store(input logic [47:0] blk, input logic [5:0] off, input bit gen);
        @(negedge clk);
        st_valid = 1'b1; st_gen = gen; st_addr = {blk, off};
        @(negedge clk);
        st_valid = 1'b0; st_gen = 1'b0;
    endtask

    task automatic marshal(input logic [4:0] dest);
        @(negedge clk);
        mcmd_valid = 1'b1; mcmd_dest = dest;
        @(negedge clk);
        mcmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R8 done seen"}, {63'd0, done}, 64'd1);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, {63'd0, done}, 64'd0);
        check({tag, " R8 overflow cleared"}, {63'd0, overflow}, 64'd0);
    endtask

    task automatic clear_log();
        got_n = 0; rd_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; st_valid = 1'b0; st_gen = 1'b0; st_addr = '0;
        mcmd_valid = 1'b0; mcmd_dest = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        check("R1 busy", {63'd0, st_busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 overflow", {63'd0, overflow}, 64'd0);
        check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R1 push_valid", {63'd0, push_valid}, 64'd0);
    endtask

    task automatic t_basic();
        clear_log();
        exp_dest = 5'd5;
        store(mk_blk(1), 6'h3F, 1'b1);
        store(mk_blk(2), 6'h00, 1'b1);
        store(mk_blk(9), 6'h10, 1'b0);   // ordinary store
        store(mk_blk(1), 6'h07, 1'b1);   // duplicate block
        store(mk_blk(3), 6'h21, 1'b1);
        marshal(5'd5);
        wait_done("basic");
        check("R2 R4 push count", 64'(got_n), 64'd3);
        check("R6 read count", 64'(rd_n), 64'd3);
        check("R3 R6 first block", {16'd0, got_blk[0]}, {16'd0, mk_blk(1)});
        check("R3 R6 second block", {16'd0, got_blk[1]}, {16'd0, mk_blk(2)});
        check("R2 R6 third block", {16'd0, got_blk[2]}, {16'd0, mk_blk(3)});
    endtask

    task automatic t_empty();
        clear_log();
        exp_dest = 5'd11;
        marshal(5'd11);
        wait_done("empty");
        check("R9 R8 no push after clear", 64'(got_n), 64'd0);
        check("R9 no read", 64'(rd_n), 64'd0);
    endtask

    task automatic t_overflow();
        clear_log();
        exp_dest = 5'd30;
        for (int k = 0; k < 16; k++) store(mk_blk(100 + k), 6'(k), 1'b1);
        @(negedge clk);
        check("R5 sixteen fit", {63'd0, overflow}, 64'd0);
        store(mk_blk(200), 6'h01, 1'b1);
        @(negedge clk);
        check("R5 overflow set", {63'd0, overflow}, 64'd1);
        store(mk_blk(100), 6'h02, 1'b1);  // duplicate in full table
        repeat (3) @(negedge clk);
        check("R5 overflow sticky", {63'd0, overflow}, 64'd1);
        marshal(5'd30);
        wait_done("overflow");
        check("R5 push count", 64'(got_n), 64'd16);
        check("R6 order first", {16'd0, got_blk[0]}, {16'd0, mk_blk(100)});
        check("R6 order last", {16'd0, got_blk[15]}, {16'd0, mk_blk(115)});
    endtask

    task automatic t_busy();
        clear_log();
        exp_dest = 5'd2;
        store(mk_blk(40), 6'h00, 1'b1);
        store(mk_blk(41), 6'h00, 1'b1);
        store(mk_blk(42), 6'h00, 1'b1);
        marshal(5'd2);
        check("R7 busy after command", {63'd0, st_busy}, 64'd1);
        store(mk_blk(77), 6'h05, 1'b1);   // must be stalled
        marshal(5'd9);                   // must be ignored
        check("R7 still busy", {63'd0, st_busy}, 64'd1);
        wait_done("busy");
        check("R7 R11 push count", 64'(got_n), 64'd3);
        check("R6 busy order", {16'd0, got_blk[2]}, {16'd0, mk_blk(42)});
        check("R7 idle after done", {63'd0, st_busy}, 64'd0);
        clear_log();
        exp_dest = 5'd9;
        marshal(5'd9);
        wait_done("busy2");
        check("R7 stalled store not recorded", 64'(got_n), 64'd0);
    endtask

    task automatic t_same_cycle();
        clear_log();
        exp_dest = 5'd7;
        @(negedge clk);
        st_valid = 1'b1; st_gen = 1'b1; st_addr = {mk_blk(55), 6'h2A};
        mcmd_valid = 1'b1; mcmd_dest = 5'd7;
        @(negedge clk);
        st_valid = 1'b0; st_gen = 1'b0; mcmd_valid = 1'b0;
        wait_done("same");
        check("R10 push count", 64'(got_n), 64'd1);
        check("R10 pushed block", {16'd0, got_blk[0]}, {16'd0, mk_blk(55)});
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_empty();
        t_overflow();
        t_busy();
        t_same_cycle();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule